// File: doc/BRIEF.md
# Two-Stage Serial Clock Divider with Timeout

This block derives a serial bus clock from a fast source clock. Two stages set the divider chain, and each stage has its own programmed field. An even pre-divider comes first. A rate stage then stretches each half-period by a factor of one plus the rate value. The resulting output frequency is the source frequency divided by the even divider times (1 + rate). The output is a 50% duty square wave `sclk_o` plus a one-cycle strobe `sclk_en_o`. The strobe marks the first source cycle of every output period, so logic in the source domain can use it as a clock enable.

A timeout counter sits beside the divider and counts in units of 2^UNIT_LOG2 serial-clock periods, which is 4096 by default. A start pulse arms it with a limit. A done pulse disarms it. If the limit is reached first, it raises a sticky flag. Software picks the divide/rate pair; this block only carries the pair out.

Top module: `serclk_gen`

## Requirements
- R1: With h = div_i >> 1 (taken as 1 when that is 0) and R = rate_i, every output period lasts exactly 2·h·(1+R) source cycles, i.e. f_out = f_src / (2h·(1+R)).
- R2: The least significant bit of div_i is ignored, and div_i values 0 and 1 behave as 2, so the pre-divider is always even and at least 2.
- R3: sclk_o is high for exactly h·(1+R) source cycles of each period and low for the rest (50% duty).
- R4: sclk_en_o is high for exactly one source cycle per period: the first cycle in which sclk_o is high.
- R5: div_i and rate_i are sampled only at the start of an output period. A change during a period leaves that period's length unchanged and applies from the next period.
- R6: While rst_ni is low, sclk_o, sclk_en_o and tmo_o are 0. The first period starts on the first clock edge after reset is released.
- R7: A start_i pulse captures tmo_i as the limit L and clears tmo_o. Counting starts on the following edge. tmo_o rises in the cycle after the (L·2^UNIT_LOG2)-th sclk_en_o pulse seen from then on.
- R8: tmo_o stays high until the next accepted start_i.
- R9: done_i stops a running count, so tmo_o does not rise afterwards. When done_i and start_i are both high, done_i wins and start_i is ignored: a flag that is already set stays set.
- R10: A limit of 0 disables the timeout, and tmo_o never rises.
- R11: The full-scale limit 2^TMO_W−1 expires after exactly (2^TMO_W−1)·2^UNIT_LOG2 pulses without counter overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_i | input | DIV_W | Pre-divider value (even part used) |
| rate_i | input | RATE_W | Rate stage value, factor 1+rate |
| tmo_i | input | TMO_W | Timeout limit in units of 2^UNIT_LOG2 serial periods |
| start_i | input | 1 | Arms the timeout counter |
| done_i | input | 1 | Stops the timeout counter |
| sclk_o | output | 1 | Divided serial clock, 50% duty |
| sclk_en_o | output | 1 | One-cycle strobe at each serial clock rising edge |
| tmo_o | output | 1 | Sticky timeout flag |

## Verification
The bench builds the block with DIV_W=4, RATE_W=3, TMO_W=4 and UNIT_LOG2=3. With these values every divide/rate pair (16 × 8) can be swept, and both the period and the high time are measured for each pair, odd and sub-2 divide codes included. A timeout unit of 8 serial periods and a 4-bit limit put full-scale expiry, sticky hold, abort and the disabled limit within a few hundred cycles. A mid-period reprogramming case shows that a new pair takes effect only at the period boundary.

// File: rtl/serclk_pkg.sv
package serclk_pkg;
  typedef enum logic [1:0] {
    TMO_IDLE    = 2'd0,
    TMO_RUN     = 2'd1,
    TMO_EXPIRED = 2'd2
  } tmo_state_e;
endpackage

// File: rtl/serclk_prediv.sv
module serclk_prediv #(
  parameter int unsigned HALF_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic [HALF_W-1:0] half_i,
  output logic              tick_o
);
  localparam logic [HALF_W-1:0] ONE = HALF_W'(1);

  logic [HALF_W-1:0] cnt_q;

  assign tick_o = (cnt_q == half_i - ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i || tick_o)  cnt_q <= '0;
    else                       cnt_q <= cnt_q + ONE;
  end

  AST_PRE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < half_i); // R1
endmodule

// File: rtl/serclk_rate.sv
module serclk_rate #(
  parameter int unsigned RATE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              tick_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              half_end_o
);
  localparam logic [RATE_W-1:0] ONE = RATE_W'(1);

  logic [RATE_W-1:0] cnt_q;

  assign half_end_o = tick_i && (cnt_q == rate_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (clr_i)      cnt_q <= '0;
    else if (tick_i)     cnt_q <= half_end_o ? '0 : cnt_q + ONE;
  end

  AST_RATE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= rate_i); // R1
endmodule

// File: rtl/serclk_timeout.sv
module serclk_timeout
  import serclk_pkg::*;
#(
  parameter int unsigned TMO_W     = 16,
  parameter int unsigned UNIT_LOG2 = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic             done_i,
  input  logic [TMO_W-1:0] lim_i,
  output logic             expired_o
);
  localparam logic [TMO_W-1:0]     U_ONE = TMO_W'(1);
  localparam logic [UNIT_LOG2-1:0] S_ONE = UNIT_LOG2'(1);

  tmo_state_e           state_q;
  logic [UNIT_LOG2-1:0] sub_q;
  logic [TMO_W-1:0]     unit_q, lim_q;
  logic                 sub_last, unit_last;

  assign sub_last  = &sub_q;
  assign unit_last = (unit_q == lim_q - U_ONE);
  assign expired_o = (state_q == TMO_EXPIRED);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TMO_IDLE;
      sub_q   <= '0;
      unit_q  <= '0;
      lim_q   <= '0;
    end else if (done_i) begin
      if (state_q == TMO_RUN) state_q <= TMO_IDLE;
      sub_q  <= '0;
      unit_q <= '0;
    end else if (start_i) begin
      lim_q   <= lim_i;
      sub_q   <= '0;
      unit_q  <= '0;
      state_q <= (lim_i == '0) ? TMO_IDLE : TMO_RUN;
    end else if (state_q == TMO_RUN && tick_i) begin
      sub_q <= sub_q + S_ONE;
      if (sub_last) begin
        if (unit_last) begin
          state_q <= TMO_EXPIRED;
          unit_q  <= '0;
        end else begin
          unit_q <= unit_q + U_ONE;
        end
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == TMO_RUN) |-> (unit_q < lim_q)); // R11
  AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expired_o && !start_i) |=> expired_o); // R8
  AST_DONE_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> (state_q != TMO_RUN)); // R9
  AST_ZERO_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !done_i && lim_i == '0) |=> !expired_o); // R10
endmodule

// File: rtl/serclk_gen.sv
module serclk_gen #(
  parameter int unsigned DIV_W     = 8,
  parameter int unsigned RATE_W    = 8,
  parameter int unsigned TMO_W     = 16,
  parameter int unsigned UNIT_LOG2 = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic [TMO_W-1:0]  tmo_i,
  input  logic              start_i,
  input  logic              done_i,
  output logic              sclk_o,
  output logic              sclk_en_o,
  output logic              tmo_o
);
  localparam int unsigned       HALF_W   = DIV_W - 1;
  localparam logic [HALF_W-1:0] HALF_MIN = HALF_W'(1);

  logic [HALF_W-1:0] half_req, half_q;
  logic [RATE_W-1:0] rate_q;
  logic              fresh_q, sclk_q, sclk_en_q;
  logic              tick, half_end, rise;

  // even pre-divider: LSB dropped, floor of 2
  assign half_req = (div_i[DIV_W-1:1] == '0) ? HALF_MIN : div_i[DIV_W-1:1];
  assign rise     = fresh_q | (half_end & ~sclk_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fresh_q   <= 1'b1;
      half_q    <= HALF_MIN;
      rate_q    <= '0;
      sclk_q    <= 1'b0;
      sclk_en_q <= 1'b0;
    end else begin
      fresh_q   <= 1'b0;
      sclk_en_q <= rise;
      if (rise) begin
        half_q <= half_req;
        rate_q <= rate_i;
        sclk_q <= 1'b1;
      end else if (half_end) begin
        sclk_q <= 1'b0;
      end
    end
  end

  serclk_prediv #(.HALF_W(HALF_W)) u_prediv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (fresh_q),
    .half_i (half_q),
    .tick_o (tick)
  );

  serclk_rate #(.RATE_W(RATE_W)) u_rate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (fresh_q),
    .tick_i     (tick),
    .rate_i     (rate_q),
    .half_end_o (half_end)
  );

  serclk_timeout #(.TMO_W(TMO_W), .UNIT_LOG2(UNIT_LOG2)) u_tmo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (sclk_en_q),
    .start_i   (start_i),
    .done_i    (done_i),
    .lim_i     (tmo_i),
    .expired_o (tmo_o)
  );

  assign sclk_o    = sclk_q;
  assign sclk_en_o = sclk_en_q;

  AST_EN_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_q) |-> sclk_en_q); // R4
  AST_EN_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_en_q |-> sclk_q); // R4
  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rise |=> ($stable(half_q) && $stable(rate_q))); // R5
  AST_HALF_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_q != '0); // R2
endmodule

// File: tb/sim_serclk_gen.sv
module sim_serclk_gen;
  localparam int DIV_W = 4, RATE_W = 3, TMO_W = 4, UNIT_LOG2 = 3;
  localparam int UNIT = 1 << UNIT_LOG2;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [DIV_W-1:0]  div_i  = 4;
  logic [RATE_W-1:0] rate_i = 1;
  logic [TMO_W-1:0]  tmo_i  = 0;
  logic start_i = 1'b0, done_i = 1'b0;
  logic sclk_o, sclk_en_o, tmo_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  serclk_gen #(.DIV_W(DIV_W), .RATE_W(RATE_W), .TMO_W(TMO_W), .UNIT_LOG2(UNIT_LOG2)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .div_i(div_i), .rate_i(rate_i), .tmo_i(tmo_i),
    .start_i(start_i), .done_i(done_i), .sclk_o(sclk_o), .sclk_en_o(sclk_en_o), .tmo_o(tmo_o)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_en();
    do @(negedge clk); while (!sclk_en_o);
  endtask

  // standing on an en negedge; returns on the next one
  task automatic measure(output int len, output int hi);
    len = 0; hi = 0;
    do begin
      hi += int'(sclk_o); len++;
      @(negedge clk);
    end while (!sclk_en_o);
  endtask

  task automatic set_cfg(int d, int r);
    div_i = DIV_W'(d); rate_i = RATE_W'(r);
    wait_en();
  endtask

  // start a timeout of limit lim and watch for cyc cycles
  task automatic run_tmo(int lim, int cyc, string tag);
    int cnt = 0;
    int n = lim * UNIT;
    tmo_i = TMO_W'(lim); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    chk("R7 flag cleared by start", int'(tmo_o), 0);
    for (int i = 0; i < cyc; i++) begin
      chk(tag, int'(tmo_o), int'(lim != 0 && cnt >= n));
      if (sclk_en_o) cnt++;
      @(negedge clk);
    end
  endtask

  initial begin
    int len, hi, h;
    repeat (3) @(negedge clk);
    // R6 reset state
    chk("R6 sclk_o in reset", int'(sclk_o), 0);
    chk("R6 sclk_en_o in reset", int'(sclk_en_o), 0);
    chk("R6 tmo_o in reset", int'(tmo_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R6 first period starts", int'(sclk_en_o), 1);
    chk("R6 sclk_o high at start", int'(sclk_o), 1);

    // R1 R2 R3 exhaustive sweep
    for (int d = 0; d < (1 << DIV_W); d++) begin
      for (int r = 0; r < (1 << RATE_W); r++) begin
        set_cfg(d, r);
        measure(len, hi);
        h = (d >> 1) == 0 ? 1 : (d >> 1);
        chk((d < 2 || d % 2 == 1) ? "R2 period, odd/low divide" : "R1 period", len, 2 * h * (1 + r));
        chk("R3 high time", hi, h * (1 + r));
      end
    end

    // R4 strobe single cycle
    set_cfg(6, 2);
    @(negedge clk);
    chk("R4 strobe lasts one cycle", int'(sclk_en_o), 0);

    // R5 mid-period change
    set_cfg(6, 1);
    wait_en();
    len = 0; hi = 0;
    do begin
      hi += int'(sclk_o); len++;
      if (len == 2) begin div_i = 2; rate_i = 2; end
      @(negedge clk);
    end while (!sclk_en_o);
    chk("R5 current period unchanged", len, 12);
    measure(len, hi);
    chk("R5 next period uses new setting", len, 6);
    chk("R5 next high time", hi, 3);

    // timeout with fastest clock
    set_cfg(2, 0);
    wait_en();
    run_tmo(2, 60, "R7 expiry at limit");
    run_tmo(2, 60, "R8 sticky after expiry");
    run_tmo(15, 300, "R11 full-scale expiry");
    run_tmo(0, 200, "R10 zero limit disabled");
    // R9 abort
    tmo_i = 3; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    repeat (10) @(negedge clk);
    done_i = 1'b1;
    @(negedge clk); done_i = 1'b0;
    for (int i = 0; i < 100; i++) begin
      chk("R9 no expiry after done", int'(tmo_o), 0);
      @(negedge clk);
    end
    // R9 done wins over start
    run_tmo(1, 30, "R7 short limit");
    tmo_i = 5; start_i = 1'b1; done_i = 1'b1;
    @(negedge clk); start_i = 1'b0; done_i = 1'b0;
    for (int i = 0; i < 40; i++) begin
      chk("R9 start ignored under done", int'(tmo_o), 1);
      @(negedge clk);
    end

    // R7 with slower clock: period 8, limit 2 -> 16 pulses
    set_cfg(4, 1);
    wait_en();
    run_tmo(2, 160, "R7 expiry slow clock");

    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule